// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host read and write one byte at a time in an external asynchronous static RAM of 32768 bytes. The host offers a request (address, write flag, write data) on a valid/ready handshake. The controller registers the request, then drives the active-low chip-select, output-enable and write-strobe pins, the address bus, and a split data bus (out, out-enable, in) through a fixed sequence of phases.

Each phase lasts a whole number of clocks. That number comes from a nanosecond limit and the clock-period parameter: the ceiling of limit over period, and at least one cycle. A read holds the select and output-enable pins low long enough for the slowest of the cycle, address-access and output-enable limits. It captures the bus on the last of those cycles and returns the byte with a one-cycle valid pulse. It then leaves the bus undriven for a turnaround period before it accepts a new request. A write lowers the select pin one cycle before the write strobe and raises the write strobe one cycle before the select pin, so the strobe alone times the write. Address and write data stay constant throughout.

With the default parameters (8 ns clock), one read occupies 9 strobe cycles plus 4 turnaround cycles. One write occupies 10 cycles.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, reqReady is 1, sramCeN, sramOeN and sramWeN are 1, sramDqOe is 0 and rspValid is 0.
- R2: sramCeN is 1 whenever reqReady is 1, and a request is taken only on a clock edge where reqValid and reqReady are both 1.
- R3: A read holds sramCeN=0, sramOeN=0 and sramWeN=1 for exactly RD_CYC = max(ceil(70/P), ceil(35/P)) cycles. P is the clock period in ns, so RD_CYC is 9 at the default. The byte on sramDqIn during the last of those cycles is returned on rspData together with a rspValid pulse that lasts exactly one cycle.
- R4: sramDqOe is never 1 while sramOeN is 0. After a read, all strobes stay high and the bus stays undriven for HZ_CYC = ceil(25/P) cycles (4 at the default). The total busy time, during which reqReady is 0, is RD_CYC + HZ_CYC cycles.
- R5: A write lowers sramCeN one cycle before sramWeN falls. It holds sramWeN low for WP_CYC = max(ceil(50/P), ceil(60/P), ceil(30/P), ceil(70/P)-2) cycles, which is 8 at the default. It raises sramWeN one cycle before sramCeN rises, and sramOeN stays 1 throughout.
- R6: During a write, sramDqOe is 1 for every cycle in which sramCeN is 0, and sramDqOut equals the accepted write data and does not change. The busy time of a write is WP_CYC + 2 cycles.
- R7: sramAddr equals the accepted address and does not change while sramCeN is 0.
- R8: A byte written to an address is returned by a later read of that address. Addresses 0 and 32767 both work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 15 | Byte address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle pulse: read byte on rspData |
| rspData | output | 8 | Read byte |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramAddr | output | 15 | Address bus |
| sramDqOut | output | 8 | Data bus, driven value |
| sramDqOe | output | 1 | Data bus driver enable |
| sramDqIn | input | 8 | Data bus, sampled value |

## Verification
The strobe-ordering and hold properties rely on no input except reset. The rspValid and capture properties assume only that reset is applied before the first request and that request fields carry known values whenever reqValid is 1. The bench changes request fields only at the falling edge and holds reqValid until the handshake. Its memory model puts the stored byte on the bus only on the final cycle of a full-length read and puts junk there otherwise, so a capture made too early returns wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic capture;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WRECOV = 3'd5
  } state_t;

  function automatic int nsToCyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_WP_NS   = 50,
  parameter int T_WC_NS   = 70,
  parameter int T_AW_NS   = 60,
  parameter int T_DW_NS   = 30,
  parameter int T_HZ_NS   = 25
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    load,
  output strobe_t strobe
);

  // phase lengths in cycles
  localparam int RD_CYC = maxOf(maxOf(nsToCyc(T_RC_NS, CLK_NS), nsToCyc(T_AA_NS, CLK_NS)),
                                nsToCyc(T_OE_NS, CLK_NS));
  localparam int WC_REM = maxOf(nsToCyc(T_WC_NS, CLK_NS) - 2, 1);
  localparam int WP_CYC = maxOf(maxOf(nsToCyc(T_WP_NS, CLK_NS), nsToCyc(T_AW_NS, CLK_NS)),
                                maxOf(nsToCyc(T_DW_NS, CLK_NS), WC_REM));
  localparam int HZ_CYC = nsToCyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WP_CYC), HZ_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LAST = CNT_W'(HZ_CYC - 1);

  state_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic cntZero;

  assign cntZero  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);
  assign load     = reqReady && reqValid;

  always_comb begin
    stateNxt = state;
    cntNxt   = cntZero ? '0 : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            stateNxt = ST_WSETUP;
            cntNxt   = '0;
          end else begin
            stateNxt = ST_READ;
            cntNxt   = RD_LAST;
          end
        end
      end
      ST_READ: begin
        if (cntZero) begin
          stateNxt = ST_TURN;
          cntNxt   = HZ_LAST;
        end
      end
      ST_TURN: begin
        if (cntZero) stateNxt = ST_IDLE;
      end
      ST_WSETUP: begin
        stateNxt = ST_WPULSE;
        cntNxt   = WP_LAST;
      end
      ST_WPULSE: begin
        if (cntZero) stateNxt = ST_WRECOV;
      end
      ST_WRECOV: begin
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  // strobes decoded from registered state only
  always_comb begin
    strobe.ceN     = !(state == ST_READ || state == ST_WSETUP ||
                       state == ST_WPULSE || state == ST_WRECOV);
    strobe.oeN     = (state != ST_READ);
    strobe.weN     = (state != ST_WPULSE);
    strobe.drive   = (state == ST_WSETUP || state == ST_WPULSE || state == ST_WRECOV);
    strobe.capture = (state == ST_READ) && cntZero;
  end

  // R5: write strobe only inside chip select
  a_r5_we_within_ce: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.weN |-> !strobe.ceN);
  // R5: write strobe falls only after chip select was already low
  a_r5_we_fall_late: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.weN) |-> $past(!strobe.ceN));
  // R5: chip select rises only after write strobe was already high
  a_r5_ce_rise_late: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.ceN) |-> $past(strobe.weN));
  // R4: no bus drive while the device may drive
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drive |-> strobe.oeN);
  // R2: idle means standby
  a_r2_ready_standby: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> strobe.ceN);
  // R3: capture only under a read strobe
  a_r3_capture_in_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (!strobe.ceN && !strobe.oeN && strobe.weN));

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddr  <= '0;
      sramDqOut <= '0;
    end else if (load) begin
      sramAddr  <= reqAddr;
      sramDqOut <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= sramDqIn;
    end
  end

  assign sramCeN  = strobe.ceN;
  assign sramOeN  = strobe.oeN;
  assign sramWeN  = strobe.weN;
  assign sramDqOe = strobe.drive;

  // R7: address held while selected
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ceN && $past(!strobe.ceN)) |-> $stable(sramAddr));
  // R6: write data held while driven
  a_r6_wdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && $past(strobe.drive)) |-> $stable(sramDqOut));
  // R3: response valid lasts one cycle
  a_r3_single_valid: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 8,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_WP_NS = 50,
  parameter int T_WC_NS = 70,
  parameter int T_AW_NS = 60,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  strobe_t strobe;
  logic    load;

  asram_ctl #(
    .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS),
    .T_WP_NS(T_WP_NS), .T_WC_NS(T_WC_NS), .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS),
    .T_HZ_NS(T_HZ_NS)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .load     (load),
    .strobe   (strobe)
  );

  asram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .load      (load),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .strobe    (strobe),
    .sramDqIn  (sramDqIn),
    .sramAddr  (sramAddr),
    .sramDqOut (sramDqOut),
    .sramDqOe  (sramDqOe),
    .sramCeN   (sramCeN),
    .sramOeN   (sramOeN),
    .sramWeN   (sramWeN),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  // 8 ns clock: 70/8 -> 9, 25/8 -> 4, max(50,60,30 ns, 70 ns - 2 cycles) -> 8
  localparam int RD_EXP = 9;
  localparam int HZ_EXP = 4;
  localparam int WP_EXP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rspValid, sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [7:0] rspData, sramDqOut;
  logic [14:0] sramAddr;
  logic [7:0] sramDqIn = 8'hEE;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  logic [7:0] model [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] initVal(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] shadowRead(input logic [14:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : initVal(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // device model and pin monitor, all at the falling edge
  logic prevCeN = 1'b1, prevWeN = 1'b1;
  logic [7:0] prevDq = '0;
  logic [14:0] prevAddr = '0;
  int rdLen = 0, weLen = 0;
  logic [7:0] curData = '0;
  logic [14:0] curAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sramDqOe && !sramOeN) check(1'b0, "R4 drive under oe", 1, 0);
      if (!sramCeN && !prevCeN && sramAddr != prevAddr)
        check(1'b0, "R7 addr moved", int'(sramAddr), int'(prevAddr));
      if (!sramCeN && !sramOeN && sramWeN) rdLen++;
      if (!sramWeN) weLen++;
      if (!sramWeN && prevWeN)
        check(!prevCeN, "R5 ce low before we", int'(prevCeN), 0);
      if (sramWeN && !prevWeN) begin
        check(!sramCeN, "R5 we rises before ce", int'(sramCeN), 0);
        check(weLen == WP_EXP, "R5 we width", weLen, WP_EXP);
        check(prevDq == curData, "R6 write data", int'(prevDq), int'(curData));
        model[int'(prevAddr)] = prevDq;
        weLen = 0;
      end
      if (!sramCeN && !sramOeN && sramWeN)
        sramDqIn = (rdLen == RD_EXP) ?
          (model.exists(int'(sramAddr)) ? model[int'(sramAddr)] : initVal(sramAddr)) :
          ~initVal(sramAddr);
      else
        sramDqIn = 8'hEE;
      if (!sramCeN && sramWeN == 1'b1 && prevCeN == 1'b1 && sramOeN)
        check(sramDqOe, "R6 drive from select", int'(sramDqOe), 1);
      if (sramCeN && !prevCeN) begin
        if (rdLen != 0) check(rdLen == RD_EXP, "R3 read width", rdLen, RD_EXP);
        rdLen = 0;
      end
      if (!sramCeN && !sramWeN && !sramOeN) check(1'b0, "R5 oe during write", 0, 1);
    end
    prevCeN  = sramCeN;
    prevWeN  = sramWeN;
    prevDq   = sramDqOut;
    prevAddr = sramAddr;
  end

  task automatic doOp(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int busy;
    int pulses;
    logic [7:0] got;
    busy = 0;
    pulses = 0;
    got = '0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    check(sramCeN, "R2 standby when ready", int'(sramCeN), 1);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr = a;
    reqWdata = d;
    curData = d;
    curAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = $urandom_range(0, 1);
    reqAddr = 15'($urandom);
    reqWdata = 8'($urandom);
    while (!reqReady) begin
      busy++;
      if (!sramCeN) check(sramAddr == curAddr, "R7 addr value", int'(sramAddr), int'(curAddr));
      if (wr && !sramCeN) check(sramDqOe, "R6 drive while selected", int'(sramDqOe), 1);
      if (rspValid) begin
        pulses++;
        got = rspData;
      end
      if (busy > 100) break;
      @(negedge clk);
    end
    if (rspValid) pulses++;
    if (wr) begin
      check(busy == WP_EXP + 2, "R6 write busy", busy, WP_EXP + 2);
      check(pulses == 0, "R3 no valid on write", pulses, 0);
      shadow[int'(a)] = d;
    end else begin
      check(busy == RD_EXP + HZ_EXP, "R4 read busy", busy, RD_EXP + HZ_EXP);
      check(pulses == 1, "R3 one valid pulse", pulses, 1);
      check(got == shadowRead(a), "R8 read data", int'(got), int'(shadowRead(a)));
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
    check({sramCeN, sramOeN, sramWeN} == 3'b111, "R1 strobes", int'({sramCeN, sramOeN, sramWeN}), 7);
    check(!sramDqOe && !rspValid, "R1 bus and valid", int'({sramDqOe, rspValid}), 0);
    rstN = 1'b1;
    // R2: held valid at reset release is only taken once idle
    doOp(1'b0, 15'h0000, 8'h00);
    doOp(1'b1, 15'h0000, 8'hA5);
    doOp(1'b1, 15'h7FFF, 8'h3C);
    doOp(1'b0, 15'h7FFF, 8'h00);
    doOp(1'b0, 15'h0000, 8'h00);
    doOp(1'b1, 15'h0000, 8'h00);
    doOp(1'b0, 15'h0000, 8'h00);
    doOp(1'b1, 15'h1234, 8'hFF);
    doOp(1'b1, 15'h1234, 8'h5E);
    doOp(1'b0, 15'h1234, 8'h00);
    for (int i = 0; i < 80; i++) begin
      logic [14:0] a;
      a = ($urandom_range(0, 1) == 0) ? 15'($urandom_range(0, 15)) : 15'($urandom);
      doOp($urandom_range(0, 2) == 0, a, 8'($urandom));
    end
    foreach (shadow[k]) begin
      logic [7:0] m;
      m = model.exists(k) ? model[k] : 8'hxx;
      check(m === shadow[k], "R8 array content", int'(m), int'(shadow[k]));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule